// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

This block produces the serial bit clock and the frame sync for a PCM or TDM audio port, entirely inside one system clock domain. The two candidate timebases arrive as clock-enable strobes. One of them is selected, and its strobes are counted by an 8-bit programmable divider that follows an N+1 rule to form the bit clock. A 7-bit frame divider, also N+1, counts bit periods to mark frame boundaries. The frame sync is either a short pulse one bit wide or a long pulse whose width comes from a small set of codec-friendly lengths.

Each bit-clock rising edge is announced by a one-cycle strobe, `bclk_edge`. Transmit logic launches data on this strobe, and the frame sync and frame-start pulse change only on it. Configuration inputs are plain control pins. While `enable` is low they are captured continuously. While running they are captured only at each frame boundary, so a change made in the middle of a frame never produces a short or torn frame. There is no streaming data path, so no valid/ready handshake is involved.

Top module: `audio_clk_gen`

## Requirements
- R1: While reset is asserted, `bclk`, `bclk_edge`, `fsync` and `frame_start` are 0. One clock after `enable` is sampled low, the same four outputs are 0.
- R2: `src_sel`=0 selects strobe `tick_a` and `src_sel`=1 selects `tick_b`. The bit period is (P+1) strobes of the selected source, where P is `bit_div`.
- R3: A `bit_div` value of 0 is handled as 1, which gives a divide by 2.
- R4: `bclk` rises in the same cycle that `bclk_edge` is high. It stays high for floor((P+1)/2) selected strobes and stays low for the rest of the bit period.
- R5: A frame lasts max(F,15)+1 bit periods, where F is `frame_div`. A `frame_div` below 15 therefore still gives a 16-bit frame.
- R6: With `long_sync`=0, `fsync` is high for exactly the first bit period of each frame.
- R7: With `long_sync`=1, `fsync` is high for the first L bit periods of the frame. The 3-bit `sync_len` maps 0→6, 1→13, 2→14, 3→15 and 4→16. Codes 5 to 7 give 16.
- R8: A change of `src_sel`, `bit_div`, `frame_div`, `long_sync` or `sync_len` while running has no effect on the current frame. It takes effect from the next frame boundary.
- R9: `frame_start` is a one-cycle pulse that occurs only together with `bclk_edge`, and `fsync` is high in that cycle. `fsync` changes only in a cycle where `bclk_edge` is high, or when `enable` drops.
- R10: After `enable` rises, the first selected strobe starts a frame. `frame_start` and `bclk_edge` appear one clock after that strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; low clears counters and outputs |
| src_sel | input | 1 | Timebase select: 0 = tick_a, 1 = tick_b |
| tick_a | input | 1 | Primary timebase clock-enable strobe |
| tick_b | input | 1 | Secondary timebase clock-enable strobe |
| bit_div | input | 8 | Bit-clock prescaler P, divide by P+1 |
| frame_div | input | 7 | Frame prescaler F, bits per frame minus one |
| long_sync | input | 1 | 0 = one-bit sync, 1 = long sync |
| sync_len | input | 3 | Long sync width code |
| bclk | output | 1 | Serial bit clock |
| bclk_edge | output | 1 | One-cycle strobe on each bclk rising edge |
| fsync | output | 1 | Frame sync |
| frame_start | output | 1 | One-cycle pulse on the first bit of a frame |

## Verification
A bit divider in a wrong state shows up within one bit period as a wrong spacing between `bclk_edge` strobes or a wrong high time of `bclk`. A wrong frame counter or sync decode becomes visible within one frame, as a wrong count of edges between `frame_start` pulses or a wrong count of edges with `fsync` high. Shadow-capture faults show up only in the frame that straddles a configuration change, so that frame is measured edge by edge, together with the frame that follows it.

// File: rtl/acg_pkg.sv
package acg_pkg;
  localparam int SYNC_CODE_W = 3;
  localparam int SYNC_LEN_W  = 5;

  // Long sync width in bit periods for a given code
  function automatic logic [SYNC_LEN_W-1:0] sync_width(input logic [SYNC_CODE_W-1:0] code);
    case (code)
      3'd0:    sync_width = 5'd6;
      3'd1:    sync_width = 5'd13;
      3'd2:    sync_width = 5'd14;
      3'd3:    sync_width = 5'd15;
      default: sync_width = 5'd16;
    endcase
  endfunction
endpackage

// File: rtl/acg_bit_div.sv
module acg_bit_div #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] div,
  output logic         adv,
  output logic         first,
  output logic         bclk,
  output logic         edge_q
);
  logic [W-1:0] cnt;
  logic         running;
  logic [W-1:0] divc;
  logic [W:0]   half;
  logic [W:0]   nxt;

  assign divc  = (div == '0) ? W'(1) : div;
  assign half  = ({1'b0, divc} + (W+1)'(1)) >> 1;
  assign nxt   = {1'b0, cnt} + (W+1)'(1);
  assign first = !running;
  assign adv   = en && tick && (!running || cnt == divc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
      bclk    <= 1'b0;
      edge_q  <= 1'b0;
    end else if (!en) begin
      cnt     <= '0;
      running <= 1'b0;
      bclk    <= 1'b0;
      edge_q  <= 1'b0;
    end else begin
      edge_q <= adv;
      if (adv) begin
        running <= 1'b1;
        cnt     <= '0;
        bclk    <= 1'b1;
      end else if (tick) begin
        cnt <= nxt[W-1:0];
        if (nxt == half) bclk <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/acg_frame_seq.sv
module acg_frame_seq
  import acg_pkg::*;
#(
  parameter int FW        = 7,
  parameter int MIN_FRAME = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   adv,
  input  logic                   first,
  input  logic [FW-1:0]          fdiv,
  input  logic                   long_mode,
  input  logic [SYNC_CODE_W-1:0] code,
  output logic                   boundary,
  output logic                   fsync,
  output logic                   frame_start
);
  localparam logic [FW-1:0] FLOOR = FW'(MIN_FRAME - 1);

  logic [FW-1:0]         fbit;
  logic [FW-1:0]         fmax;
  logic [FW:0]           fnext;
  logic [SYNC_LEN_W-1:0] len;

  assign fmax     = (fdiv < FLOOR) ? FLOOR : fdiv;
  assign fnext    = {1'b0, fbit} + (FW+1)'(1);
  assign len      = sync_width(code);
  assign boundary = adv && (first || fbit == fmax);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbit        <= '0;
      fsync       <= 1'b0;
      frame_start <= 1'b0;
    end else if (!en) begin
      fbit        <= '0;
      fsync       <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= boundary;
      if (boundary) begin
        fbit  <= '0;
        fsync <= 1'b1;
      end else if (adv) begin
        fbit  <= fnext[FW-1:0];
        fsync <= long_mode && (fnext < (FW+1)'(len));
      end
    end
  end
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen
  import acg_pkg::*;
#(
  parameter int BDIV_W    = 8,
  parameter int FDIV_W    = 7,
  parameter int MIN_FRAME = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              src_sel,
  input  logic              tick_a,
  input  logic              tick_b,
  input  logic [BDIV_W-1:0] bit_div,
  input  logic [FDIV_W-1:0] frame_div,
  input  logic              long_sync,
  input  logic [2:0]        sync_len,
  output logic              bclk,
  output logic              bclk_edge,
  output logic              fsync,
  output logic              frame_start
);
  logic                   sel_sh;
  logic [BDIV_W-1:0]      bdiv_sh;
  logic [FDIV_W-1:0]      fdiv_sh;
  logic                   long_sh;
  logic [SYNC_CODE_W-1:0] code_sh;
  logic                   tick;
  logic                   adv;
  logic                   first;
  logic                   boundary;

  // Settings are captured while idle and at each frame boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_sh  <= 1'b0;
      bdiv_sh <= '0;
      fdiv_sh <= '0;
      long_sh <= 1'b0;
      code_sh <= '0;
    end else if (!enable || boundary) begin
      sel_sh  <= src_sel;
      bdiv_sh <= bit_div;
      fdiv_sh <= frame_div;
      long_sh <= long_sync;
      code_sh <= sync_len;
    end
  end

  assign tick = sel_sh ? tick_b : tick_a;

  acg_bit_div #(.W(BDIV_W)) u_bit (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (enable),
    .tick   (tick),
    .div    (bdiv_sh),
    .adv    (adv),
    .first  (first),
    .bclk   (bclk),
    .edge_q (bclk_edge)
  );

  acg_frame_seq #(.FW(FDIV_W), .MIN_FRAME(MIN_FRAME)) u_frm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (enable),
    .adv         (adv),
    .first       (first),
    .fdiv        (fdiv_sh),
    .long_mode   (long_sh),
    .code        (code_sh),
    .boundary    (boundary),
    .fsync       (fsync),
    .frame_start (frame_start)
  );
endmodule

// File: rtl/acg_checker.sv
module acg_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic bclk,
  input logic bclk_edge,
  input logic fsync,
  input logic frame_start
);
  // R4
  edge_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_edge |-> $rose(bclk));
  // R9
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (bclk_edge && fsync));
  // R9
  sync_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !bclk_edge) |-> $stable(fsync));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bclk && !bclk_edge && !fsync && !frame_start));
  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
endmodule

bind audio_clk_gen acg_checker chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .bclk        (bclk),
  .bclk_edge   (bclk_edge),
  .fsync       (fsync),
  .frame_start (frame_start)
);

// File: tb/tb_audio_clk_gen.sv
module tb_audio_clk_gen;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       enable = 0;
  logic       src_sel = 0;
  logic       tick_a = 1;
  logic       tick_b = 0;
  logic [7:0] bit_div = 1;
  logic [6:0] frame_div = 15;
  logic       long_sync = 0;
  logic [2:0] sync_len = 0;
  logic       bclk, bclk_edge, fsync, frame_start;

  int checks = 0;
  int errors = 0;

  audio_clk_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .src_sel(src_sel),
    .tick_a(tick_a), .tick_b(tick_b), .bit_div(bit_div), .frame_div(frame_div),
    .long_sync(long_sync), .sync_len(sync_len),
    .bclk(bclk), .bclk_edge(bclk_edge), .fsync(fsync), .frame_start(frame_start)
  );

  always #5 clk = ~clk;

  // secondary timebase: one strobe every second cycle
  initial forever begin
    @(negedge clk);
    tick_b = ~tick_b;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    errors++;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_sync(input bit lng, input int code);
    if (!lng) return 1;
    case (code)
      0: return 6;
      1: return 13;
      2: return 14;
      3: return 15;
      default: return 16;
    endcase
  endfunction

  function automatic int exp_frame(input int fd);
    return (fd < 15) ? 16 : fd + 1;
  endfunction

  function automatic int eff_div(input int bd);
    return (bd == 0) ? 1 : bd;
  endfunction

  function automatic int exp_per(input int bd, input bit sel);
    return (eff_div(bd) + 1) * (sel ? 2 : 1);
  endfunction

  function automatic int exp_hi(input int bd, input bit sel);
    return ((eff_div(bd) + 1) / 2) * (sel ? 2 : 1);
  endfunction

  // Measure one complete frame starting at the next frame_start
  task automatic measure(output int per, output int hi, output int flen, output int slen);
    bit got = 0;
    int cyc = 0;
    do @(negedge clk); while (!frame_start);
    flen = 1;
    slen = fsync ? 1 : 0;
    hi   = bclk ? 1 : 0;
    per  = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!got && !bclk_edge && bclk) hi++;
      if (bclk_edge) begin
        if (!got) begin per = cyc; got = 1; end
        if (frame_start) break;
        flen++;
        if (fsync) slen++;
      end
    end
  endtask

  task automatic setup(input bit sel, input int bd, input int fd, input bit lng, input int code);
    enable = 0;
    repeat (2) @(negedge clk);
    src_sel   = sel;
    bit_div   = 8'(bd);
    frame_div = 7'(fd);
    long_sync = lng;
    sync_len  = 3'(code);
    @(negedge clk);
    enable = 1;
  endtask

  task automatic run_case(input bit sel, input int bd, input int fd, input bit lng, input int code);
    int per, hi, flen, slen;
    setup(sel, bd, fd, lng, code);
    measure(per, hi, flen, slen);
    chk(per == exp_per(bd, sel), sel ? "R2 period src b" : "R2 period src a", per, exp_per(bd, sel));
    chk(hi == exp_hi(bd, sel), "R4 bclk high time", hi, exp_hi(bd, sel));
    chk(flen == exp_frame(fd), "R5 frame length", flen, exp_frame(fd));
    chk(slen == exp_sync(lng, code), lng ? "R7 long sync width" : "R6 short sync width",
        slen, exp_sync(lng, code));
  endtask

  initial begin
    int per, hi, flen, slen, edges;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(bclk == 0, "R1 reset bclk", bclk, 0);
    chk(bclk_edge == 0, "R1 reset edge", bclk_edge, 0);
    chk(fsync == 0, "R1 reset fsync", fsync, 0);
    chk(frame_start == 0, "R1 reset frame_start", frame_start, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R10 first strobe after enable starts a frame
    src_sel = 0; bit_div = 3; frame_div = 15;
    enable = 1;
    @(negedge clk);
    chk(frame_start == 1 && bclk_edge == 1, "R10 start after enable", frame_start, 1);

    // R3 divider zero handled as one; R5 short frame clamp
    run_case(0, 0, 3, 0, 0);
    run_case(1, 0, 0, 1, 2);
    // bit_div 46 gives divide by 47
    run_case(0, 46, 15, 0, 0);
    // every long sync code
    for (int c = 0; c < 8; c++) run_case(c[0], 2, 20, 1, c);

    // R8 mid-frame change
    setup(0, 1, 20, 1, 4);
    do @(negedge clk); while (!frame_start);
    edges = 1;
    forever begin
      @(negedge clk);
      if (bclk_edge) begin
        if (frame_start) break;
        edges++;
        if (edges == 4) begin frame_div = 31; sync_len = 0; bit_div = 3; end
      end
    end
    chk(edges == 21, "R8 current frame unchanged", edges, 21);
    measure(per, hi, flen, slen);
    chk(flen == 32, "R8 new frame length", flen, 32);
    chk(slen == 6, "R8 new sync width", slen, 6);
    chk(per == 4, "R8 new bit period", per, 4);

    // constrained random
    for (int i = 0; i < 10; i++) begin
      bit sel = 1'($urandom_range(0, 1));
      int bd  = $urandom_range(0, 6);
      int fd  = $urandom_range(0, 40);
      bit lng = 1'($urandom_range(0, 1));
      int cd  = $urandom_range(0, 7);
      run_case(sel, bd, fd, lng, cd);
    end

    // R1 disable clears outputs
    @(negedge clk);
    enable = 0;
    repeat (2) @(negedge clk);
    chk(bclk == 0, "R1 disable bclk", bclk, 0);
    chk(fsync == 0, "R1 disable fsync", fsync, 0);
    chk(frame_start == 0 && bclk_edge == 0, "R1 disable strobes", frame_start, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule